// File: doc/BRIEF.md
# Accumulator Subtract, Rotate and Pass-Through Unit with Flag Masks

This combinational unit serves as the arithmetic stage of a small accumulator CPU. It takes an accumulator operand, a second operand, the current carry flag and a 3-bit operation code. It returns a result word, a set of new condition flags and a write-enable mask. The mask tells the register file which flag bits the operation may update. The operations are plain subtract, subtract with borrow, rotate right through carry, and three pass-through moves. Two of the moves serve stores of the accumulator and of the index register. The third serves a transfer from the accumulator to the index register.

For subtraction the carry flag acts as a borrow. It comes in as a borrow and goes out as a borrow. The half-carry flag is never written by this unit, and neither is the interrupt mask, which belongs to the sequencer. Internally a small decoder turns the operation code into a struct of strobes. A datapath module consumes those strobes.

Top module: `alu8`

## Requirements
- R1: With opSel = 0 (SUB), result equals opA minus opB modulo 2^WIDTH, and carryIn has no effect on the result or on any flag.
- R2: With opSel = 1 (SBC), result equals opA minus opB minus carryIn modulo 2^WIDTH.
- R3: For SUB and SBC, flagsOut[0] (C) is 1 exactly when opB plus the borrow-in (carryIn for SBC, 0 for SUB) exceeds opA as unsigned numbers.
- R4: With opSel = 2 (ROR), result is {carryIn, opA[WIDTH-1:1]} and flagsOut[0] (C) equals opA[0].
- R5: flagsOut[2] (N) equals the top bit of result, and flagsOut[1] (Z) is 1 exactly when result is all zeros.
- R6: flagWe is {H,N,Z,C} = 4'b0111 for opSel 0, 1 and 2, 4'b0110 for opSel 3 and 4, and 4'b0000 for opSel 5, 6 and 7. flagWe[3] (H) is never set.
- R7: With opSel = 3 (store accumulator) result equals opA. With opSel = 4 (store index) result equals opB.
- R8: With opSel = 5 (transfer) and with the reserved codes 6 and 7, result equals opA and no flag is enabled.
- R9: Whenever flagWe[0] is 0, flagsOut[0] equals carryIn. flagsOut[3] (H) is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Accumulator operand |
| opB | input | WIDTH | Memory or index operand |
| carryIn | input | 1 | Current carry/borrow flag |
| opSel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| flagsOut | output | 4 | New flags {H,N,Z,C} |
| flagWe | output | 4 | Flag write enables {H,N,Z,C} |

## Verification
The bench targets the borrow boundary, where opB plus the borrow-in equals opA or exceeds it by one. A design that compares with the wrong inequality, or that drops the borrow-in from the compare, flips C at that point. It checks that SUB ignores a set carry, because a shared subtractor with the wrong select would leak it into the result. Rotates run with both carry values and with an operand that rotates to zero, which exposes swapped bit ends and a stale Z. Each move and reserved code is checked for its mask and for C left equal to carryIn, which catches a store that clobbers the carry or a transfer that writes flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_SUB = 3'd0,
    OP_SBC = 3'd1,
    OP_ROR = 3'd2,
    OP_STA = 3'd3,
    OP_STX = 3'd4,
    OP_TAX = 3'd5
  } aluOp_t;

  typedef struct packed {
    logic subEn;
    logic useCarry;
    logic rorEn;
    logic passB;
    logic weN;
    logic weZ;
    logic weC;
  } aluStrobes_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 3;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_SUB: begin
        strobes.subEn = 1'b1;
        strobes.weN = 1'b1; strobes.weZ = 1'b1; strobes.weC = 1'b1;
      end
      OP_SBC: begin
        strobes.subEn = 1'b1;
        strobes.useCarry = 1'b1;
        strobes.weN = 1'b1; strobes.weZ = 1'b1; strobes.weC = 1'b1;
      end
      OP_ROR: begin
        strobes.rorEn = 1'b1;
        strobes.weN = 1'b1; strobes.weZ = 1'b1; strobes.weC = 1'b1;
      end
      OP_STA: begin
        strobes.weN = 1'b1; strobes.weZ = 1'b1;
      end
      OP_STX: begin
        strobes.passB = 1'b1;
        strobes.weN = 1'b1; strobes.weZ = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut,
  output logic [3:0]       flagWe
);
  localparam int MSB = WIDTH - 1;
  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0]   diffExt;
  logic [EXT-1:0]   borrowExt;
  logic [WIDTH-1:0] resNext;
  logic             carryNext;
  logic             carryFinal;

  always_comb begin
    borrowExt = {{WIDTH{1'b0}}, (strobes.useCarry & carryIn)};
    diffExt   = {1'b0, opA} - {1'b0, opB} - borrowExt;
  end

  always_comb begin
    if (strobes.subEn) begin
      resNext   = diffExt[MSB:0];
      carryNext = diffExt[WIDTH];
    end else if (strobes.rorEn) begin
      resNext   = {carryIn, opA[MSB:1]};
      carryNext = opA[0];
    end else begin
      resNext   = strobes.passB ? opB : opA;
      carryNext = carryIn;
    end
    carryFinal = strobes.weC ? carryNext : carryIn;
  end

  assign result   = resNext;
  assign flagsOut = {1'b0, resNext[MSB], (resNext == '0), carryFinal};
  assign flagWe   = {1'b0, strobes.weN, strobes.weZ, strobes.weC};
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut,
  output logic [3:0]       flagWe
);
  aluStrobes_t strobes;

  alu8_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu8_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (result),
    .flagsOut (flagsOut),
    .flagWe   (flagWe)
  );
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flagsOut,
  input logic [3:0]       flagWe
);
  logic known;
  assign known = !$isunknown({opA, opB, carryIn, opSel, result, flagsOut, flagWe});

  always_comb begin
    if (known) begin
      // R6
      h_never_written_chk: assert (flagWe[3] == 1'b0);
      // R9
      h_value_zero_chk: assert (flagsOut[3] == 1'b0);
      // R9
      carry_held_chk: assert (flagWe[0] || (flagsOut[0] == carryIn));
      // R5
      zero_flag_chk: assert (flagsOut[1] == (result == '0));
      // R5
      neg_flag_chk: assert (flagsOut[2] == result[WIDTH-1]);
      // R1
      sub_result_chk: assert (opSel != 3'd0 || result == WIDTH'(opA - opB));
      // R4
      ror_shift_chk: assert (opSel != 3'd2 || (result[WIDTH-1] == carryIn && flagsOut[0] == opA[0]));
      // R8
      tax_no_flags_chk: assert (opSel < 3'd5 || flagWe == 4'b0000);
    end
  end
endmodule

bind alu8 alu8_checker #(.WIDTH(WIDTH)) u_alu8_checker (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .opSel    (opSel),
  .result   (result),
  .flagsOut (flagsOut),
  .flagWe   (flagWe)
);

// File: tb/alu8_bench.sv
module alu8_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       carryIn = 1'b0;
  logic [2:0] opSel = '0;
  logic [7:0] result;
  logic [3:0] flagsOut;
  logic [3:0] flagWe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu8 u_alu8 (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .result(result), .flagsOut(flagsOut), .flagWe(flagWe)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c, input logic [2:0] op);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; opSel = op;
    #1;
  endtask

  task automatic nzCheck(input string tag, input int expRes);
    check({tag, " R5 N"}, flagsOut[2], (expRes >> 7) & 1);
    check({tag, " R5 Z"}, flagsOut[1], (expRes == 0) ? 1 : 0);
  endtask

  task automatic testSubtract(input logic [7:0] a, input logic [7:0] b, input logic c, input bit withBorrow);
    int bin, expRes, expC;
    bin = withBorrow ? int'(c) : 0;
    expRes = (int'(a) - int'(b) - bin) & 255;
    expC = (int'(b) + bin > int'(a)) ? 1 : 0;
    apply(a, b, c, withBorrow ? 3'd1 : 3'd0);
    if (withBorrow) check("R2 sbc result", result, expRes);
    else            check("R1 sub result", result, expRes);
    check("R3 borrow", flagsOut[0], expC);
    nzCheck("sub", expRes);
    check("R6 mask", flagWe, 4'b0111);
    check("R9 H zero", flagsOut[3], 0);
  endtask

  task automatic testRotate(input logic [7:0] a, input logic c);
    int expRes;
    expRes = (int'(c) << 7) | (int'(a) >> 1);
    apply(a, 8'h00, c, 3'd2);
    check("R4 ror result", result, expRes);
    check("R4 ror carry", flagsOut[0], int'(a[0]));
    nzCheck("ror", expRes);
    check("R6 ror mask", flagWe, 4'b0111);
  endtask

  task automatic testMove(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input logic c);
    int expRes, expMask;
    expRes  = (op == 3'd4) ? int'(b) : int'(a);
    expMask = (op == 3'd3 || op == 3'd4) ? 4'b0110 : 4'b0000;
    apply(a, b, c, op);
    if (op >= 3'd5) check("R8 pass result", result, expRes);
    else            check("R7 store result", result, expRes);
    check("R6 move mask", flagWe, expMask);
    check("R9 carry held", flagsOut[0], int'(c));
    if (expMask != 0) nzCheck("store", expRes);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle inputs: SUB of zeros gives zero with Z set (R1, R5)
    apply(8'h00, 8'h00, 1'b0, 3'd0);
    check("R1 idle result", result, 0);
    check("R5 idle Z", flagsOut[1], 1);

    // R1 / R3 plain subtract, carry-in ignored
    testSubtract(8'h50, 8'h30, 1'b0, 0);
    testSubtract(8'h10, 8'h20, 1'b0, 0);
    testSubtract(8'h50, 8'h30, 1'b1, 0);
    testSubtract(8'h30, 8'h30, 1'b1, 0);
    // R2 / R3 subtract with borrow, boundary cases
    testSubtract(8'h50, 8'h30, 1'b1, 1);
    testSubtract(8'h00, 8'h00, 1'b1, 1);
    testSubtract(8'h30, 8'h30, 1'b0, 1);
    testSubtract(8'h30, 8'h30, 1'b1, 1);
    testSubtract(8'h31, 8'h30, 1'b1, 1);
    testSubtract(8'h80, 8'h01, 1'b0, 1);
    // R4 rotate
    testRotate(8'h81, 1'b0);
    testRotate(8'h02, 1'b1);
    testRotate(8'h01, 1'b0);
    testRotate(8'hFE, 1'b1);
    // R7 / R8 / R9 moves and reserved codes
    testMove(3'd3, 8'h00, 8'h55, 1'b1);
    testMove(3'd3, 8'h9A, 8'h00, 1'b0);
    testMove(3'd4, 8'h11, 8'hC3, 1'b1);
    testMove(3'd4, 8'hFF, 8'h00, 1'b0);
    testMove(3'd5, 8'h00, 8'h7E, 1'b1);
    testMove(3'd6, 8'h42, 8'h18, 1'b0);
    testMove(3'd7, 8'h80, 8'h01, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule